// File: doc/BRIEF.md
# Reconfigurable-Shape Block RAM

A synchronous single-clock memory of 2048 storage bits that can be viewed as one of four depth-by-width shapes. A 2-bit organisation input picks the shape: 256 words of 8 bits, 512 of 4, 1024 of 2 or 2048 of 1. The storage is the same in every shape, so data written under one shape can be read under another. Contents are volatile, are not cleared by reset, and hold no defined value until written.

There is one write port and one read port, both on the same clock. Addresses are always 11 bits wide, and the data lanes are always 8 wide. Only the bits that the active shape needs are used. Cell number `address * width + lane` holds a given bit. As a result, a byte written as an 8-bit word reads back as consecutive narrow words, with the least significant part at the lowest address.

Top module: `shaped_bram`

## Requirements
- R1: Organisation code `org` selects the word width: 00 gives 8 bits (256 words), 01 gives 4 bits (512 words), 10 gives 2 bits (1024 words) and 11 gives 1 bit (2048 words). A word written and read back under the same code returns the written value.
- R2: On a write, only `wr_data` lanes 0 to width-1 are stored. Lanes at or above the active width are ignored.
- R3: The read is registered. `rd_data` shows the word addressed in the cycle where `rd_en` was high, one clock edge later. Lanes at or above the width that was active at that read are 0.
- R4: Bit `l` of word `a` under width `w` is storage cell `a*w + l`. This mapping applies under every code, so a byte written with code 00 reads back with code 01 as its low nibble at address 2a and its high nibble at 2a+1, and likewise for the narrower codes.
- R5: A read and a write to the same location in the same cycle return the contents from before the write. The new value is visible to the next read.
- R6: Only the low log2(depth) bits of `wr_addr` and `rd_addr` are used. The higher address bits are ignored.
- R7: While `rd_en` is low, `rd_data` keeps its last value, even if `org` or the read address changes.
- R8: While and after reset (`rst_n` low), `rd_data` is 0 until the first read completes. Reset does not clear the storage.
- R9: While `wr_en` is low, no storage cell changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low asynchronous reset of the read pipeline |
| org | input | 2 | Organisation code (shape select) |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 11 | Write word address |
| wr_data | input | 8 | Write data lanes |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 11 | Read word address |
| rd_data | output | 8 | Registered read data lanes |

## Verification
A wrong row or lane offset shows up as a wrong bit on `rd_data` at the first read that touches the damaged cell. The reference model therefore mixes all four shapes over the same addresses, so that a misplaced bit under one shape is read back under another. A wrong write mask corrupts neighbouring lanes in the same storage row. A lost or stale read register gives the wrong word exactly one edge after the read strobe, and every cycle is compared. Holding behaviour and old-data-on-collision are visible in the very cycle after the stimulus.

// File: rtl/shaped_bram_pkg.sv
package shaped_bram_pkg;
    localparam int unsigned CELLS  = 2048;
    localparam int unsigned LANES  = 8;
    localparam int unsigned LANE_W = $clog2(LANES);
    localparam int unsigned ROWS   = CELLS / LANES;
    localparam int unsigned ROW_W  = $clog2(ROWS);
    localparam int unsigned ADDR_W = $clog2(CELLS);

    typedef enum logic [1:0] {
        ORG_X8 = 2'b00,
        ORG_X4 = 2'b01,
        ORG_X2 = 2'b10,
        ORG_X1 = 2'b11
    } org_e;
endpackage

// File: rtl/shaped_bram_locate.sv
module shaped_bram_locate
    import shaped_bram_pkg::*;
#(
    parameter int unsigned P_CELLS = CELLS,
    parameter int unsigned P_LANES = LANES
) (
    input  org_e                          org,
    input  logic [$clog2(P_CELLS)-1:0]    addr,
    output logic [$clog2(P_CELLS/P_LANES)-1:0] row,
    output logic [$clog2(P_LANES)-1:0]    col,
    output logic [P_LANES-1:0]            lane_mask
);
    localparam int unsigned AW = $clog2(P_CELLS);
    localparam int unsigned LW = $clog2(P_LANES);

    int unsigned       wlog;
    logic [AW-1:0]     keep;
    logic [AW-1:0]     cell_idx;

    always_comb begin
        wlog      = LW - int'(org);
        keep      = AW'((1 << (AW - wlog)) - 1);
        cell_idx  = (addr & keep) << wlog;
        row       = cell_idx[AW-1:LW];
        col       = cell_idx[LW-1:0];
        lane_mask = P_LANES'(((1 << (1 << wlog)) - 1) << col);
    end
endmodule

// File: rtl/shaped_bram_store.sv
module shaped_bram_store #(
    parameter int unsigned P_ROWS  = 256,
    parameter int unsigned P_LANES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(P_ROWS)-1:0]   wr_row,
    input  logic [P_LANES-1:0]          wr_mask,
    input  logic [P_LANES-1:0]          wr_bits,
    input  logic                        rd_en,
    input  logic [$clog2(P_ROWS)-1:0]   rd_row,
    output logic [P_LANES-1:0]          rd_bits
);
    typedef struct packed {
        logic [P_LANES-1:0] rd_bits;
    } store_st_t;

    logic [P_LANES-1:0] mem_q [P_ROWS];
    store_st_t st_d, st_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < int'(P_LANES); b++) begin
                if (wr_mask[b]) mem_q[wr_row][b] <= wr_bits[b];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (rd_en) st_d.rd_bits = mem_q[rd_row];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_bits = st_q.rd_bits;

    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mem_q[$past(wr_row)] & $past(wr_mask)) == ($past(wr_bits) & $past(wr_mask))));
endmodule

// File: rtl/shaped_bram_align.sv
module shaped_bram_align #(
    parameter int unsigned P_LANES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  logic [$clog2(P_LANES)-1:0]  rd_col,
    input  logic [P_LANES-1:0]          rd_mask,
    input  logic [P_LANES-1:0]          row_bits,
    output logic [P_LANES-1:0]          rd_data
);
    localparam int unsigned LW = $clog2(P_LANES);

    typedef struct packed {
        logic [P_LANES-1:0] mask;
        logic [LW-1:0]      col;
    } align_st_t;

    align_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.mask = rd_mask;
            st_d.col  = rd_col;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = (row_bits & st_q.mask) >> st_q.col;

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rd_data));

    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rd_data) < (32'd1 << $countones(st_q.mask)));
endmodule

// File: rtl/shaped_bram.sv
module shaped_bram
    import shaped_bram_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  org,
    input  logic        wr_en,
    input  logic [10:0] wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        rd_en,
    input  logic [10:0] rd_addr,
    output logic [7:0]  rd_data
);
    org_e              org_sel;
    logic [ROW_W-1:0]  w_row, r_row;
    logic [LANE_W-1:0] w_col, r_col;
    logic [LANES-1:0]  w_mask, r_mask;
    logic [LANES-1:0]  w_bits, row_bits;

    assign org_sel = org_e'(org);
    assign w_bits  = LANES'(wr_data << w_col);

    shaped_bram_locate #(.P_CELLS(CELLS), .P_LANES(LANES)) u_wloc (
        .org(org_sel), .addr(wr_addr), .row(w_row), .col(w_col), .lane_mask(w_mask)
    );

    shaped_bram_locate #(.P_CELLS(CELLS), .P_LANES(LANES)) u_rloc (
        .org(org_sel), .addr(rd_addr), .row(r_row), .col(r_col), .lane_mask(r_mask)
    );

    shaped_bram_store #(.P_ROWS(ROWS), .P_LANES(LANES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_row(w_row), .wr_mask(w_mask), .wr_bits(w_bits),
        .rd_en(rd_en), .rd_row(r_row), .rd_bits(row_bits)
    );

    shaped_bram_align #(.P_LANES(LANES)) u_align (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en),
        .rd_col(r_col), .rd_mask(r_mask), .row_bits(row_bits), .rd_data(rd_data)
    );

    p_mask_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(w_mask) == (LANES >> org)));

    p_col_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((32'(w_col) % (LANES >> org)) == 0));
endmodule

// File: tb/shaped_bram_tb.sv
`timescale 1ns/1ps
module shaped_bram_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  org = 2'b00;
    logic        wr_en = 1'b0;
    logic [10:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [10:0] rd_addr = '0;
    logic [7:0]  rd_data;

    int vectors = 0;
    int miscompares = 0;
    bit model [2048];
    logic [7:0] expect_q = 8'h00;

    always #4 clk = ~clk;

    shaped_bram u_dut (
        .clk(clk), .rst_n(rst_n), .org(org), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic compare(input string tag);
        vectors++;
        if (rd_data !== expect_q) begin
            miscompares++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, expect_q);
        end
    endtask

    task automatic step(input int m, input bit w, input int wa, input int wd,
                        input bit r, input int ra, input string tag);
        int wl    = 3 - m;
        int width = 1 << wl;
        int depth = 2048 >> wl;
        logic [7:0] e = 8'h00;
        org     = 2'(m);
        wr_en   = w;
        wr_addr = 11'(wa);
        wr_data = 8'(wd);
        rd_en   = r;
        rd_addr = 11'(ra);
        if (r) begin
            for (int l = 0; l < width; l++) e[l] = model[(ra % depth) * width + l];
            expect_q = e;
        end
        if (w) begin
            for (int l = 0; l < width; l++) model[(wa % depth) * width + l] = wd[l];
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(8 * 200000);
        miscompares++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R8 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R8 after reset");

        // fill all storage as bytes, no reads yet
        for (int i = 0; i < 256; i++) step(0, 1, i, (i * 37 + 5) & 255, 0, 0, "R9 fill");

        // R1: byte read back in byte shape
        for (int i = 0; i < 256; i++) step(0, 0, 0, 0, 1, i, "R1 x8 readback");
        // R4: same storage viewed as nibbles, pairs and single bits
        for (int i = 0; i < 64; i++) step(1, 0, 0, 0, 1, i, "R4 x4 view");
        for (int i = 0; i < 64; i++) step(2, 0, 0, 0, 1, i, "R4 x2 view");
        for (int i = 0; i < 64; i++) step(3, 0, 0, 0, 1, i, "R4 x1 view");

        // R2: upper write lanes ignored in narrow shapes
        step(3, 1, 40, 8'hFE, 0, 0, "R2 x1 write");
        step(1, 1, 9, 8'hA5, 0, 0, "R2 x4 write");
        step(2, 1, 3, 8'hFD, 0, 0, "R2 x2 write");
        step(0, 0, 0, 0, 1, 5, "R2 byte 5");
        step(0, 0, 0, 0, 1, 4, "R2 byte 4");
        step(0, 0, 0, 0, 1, 0, "R2 byte 0");

        // R6: upper address bits ignored
        step(0, 1, 11'h705, 8'h3C, 0, 0, "R6 write high addr");
        step(0, 0, 0, 0, 1, 5, "R6 read low addr");
        step(1, 0, 0, 0, 1, 11'h60A, "R6 x4 high addr");
        step(2, 0, 0, 0, 1, 11'h414, "R6 x2 high addr");

        // R5: collision returns old data, then new
        step(2, 1, 100, 3, 1, 100, "R5 collision old");
        step(2, 0, 0, 0, 1, 100, "R5 new visible");
        step(0, 1, 77, 8'h5A, 1, 77, "R5 byte collision");
        step(0, 0, 0, 0, 1, 77, "R5 byte new");

        // R7: hold while read strobe low
        step(3, 0, 0, 0, 0, 7, "R7 hold org change");
        step(1, 1, 154, 8'h0F, 0, 154, "R7 hold with write");
        step(2, 0, 0, 0, 0, 300, "R7 hold addr change");

        // R9: no change while write strobe low
        step(0, 0, 200, 8'h00, 0, 0, "R9 idle");
        step(0, 0, 0, 0, 1, 200, "R9 untouched");

        // R3: mixed traffic in all shapes
        for (int i = 0; i < 3000; i++) begin
            step(int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), int'($urandom_range(0, 2047)),
                 int'($urandom_range(0, 255)), bit'($urandom_range(0, 1)),
                 int'($urandom_range(0, 2047)), "R3 mixed");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule